// File: doc/BRIEF.md
# Velocity-Sensing Key Matrix Scanner

This block scans a musical keyboard wired as a matrix in which every key carries two contacts. The shallow contact closes early in the stroke and the deep contact closes when the key bottoms out. The block drives one scan column at a time, waits a few cycles for the lines to settle, then examines the ten keys of that column one per clock. For each key a small tracker measures how many full scan rounds pass between the two closures and converts that interval into an 8-bit velocity. A fast stroke gives a high value.

Key presses and releases become events, each a note number and a velocity. Events wait in an eight-entry queue that a host processor drains over a small parallel bus. The bus has an 8-bit bidirectional data path, a 3-bit register address and active-low chip select, read and write strobes. An active-low interrupt line tells the host that the queue holds something.

Each of the three state machines has named states and transitions:
- The scan sequencer alternates between `SP_SETTLE` and `SP_SENSE`. After `SETTLE` cycles it goes from settle to sense. After `NUM_SENSE` cycles it goes from sense back to settle and advances the column.
- Each key moves between `KS_IDLE`, `KS_ARMED` and `KS_HELD`:
  - idle to armed on a shallow closure;
  - idle to held when both contacts are closed together;
  - armed to held on a deep closure;
  - armed to idle on an aborted stroke;
  - held to idle on release.
- The host port moves from `HP_IDLE` to `HP_NOTE_RD` while a note-register read strobe is active. It returns to `HP_IDLE` when that strobe ends, and the head entry is removed at that moment.

Top module: `velo_keyscan`

## Requirements
- R1: `scan_o` has exactly one bit high, and after reset it is column 0 (value 1). Each column is held for `SETTLE + NUM_SENSE` cycles (12 by default). The columns then advance 0, 1, …, 7 and wrap.
- R2: An event's note number is column × 10 + sense index, read back from register 1.
- R3: A key's delay `n` is the number of scan rounds between its shallow and deep closures being seen. A note-on has velocity 255 when `n` is 0 (both contacts closed together) or 1, and velocity 256 − `n` otherwise.
- R4: The interval count saturates, and the note-on velocity never drops below 1. A delay of 254 rounds gives 2, and any delay of 255 rounds or more gives 1.
- R5: If the shallow contact opens before the deep contact is seen, the key returns to idle and no event is queued.
- R6: When a held key's shallow contact opens, a note-off event with velocity 0 is queued.
- R7: Key positions 61 to 79 never queue an event, even with both contacts closed.
- R8: Events leave the queue in arrival order. Register 2 returns the head velocity without removing the entry. Register 1 returns the head note, and the entry is removed when that read strobe ends. Both registers read 0 while the queue is empty.
- R9: Register 0 reads bit 0 = queue not empty and bit 1 = overflow, with the other bits 0. Addresses 4 to 7 read 0. `irq_n` is low exactly when the queue is not empty.
- R10: An event that arrives while the queue holds 8 entries is dropped and sets the overflow bit. A write to register 3 clears the overflow bit.
- R11: When the queue is full, an event arriving on the same clock edge as the end of a note read is accepted. In that case the overflow bit stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_o | output | NUM_SCAN | One-hot column drive |
| first_i | input | NUM_SENSE | Shallow-contact sense lines, high = closed |
| second_i | input | NUM_SENSE | Deep-contact sense lines, high = closed |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Register address |
| data_io | inout | 8 | Host data bus, driven only during a selected read |
| irq_n | output | 1 | Event waiting, active low |

## Verification
The queue can lose an entry to the host and gain one from a key on the same clock edge. This matters most when the queue is already full, because a wrong ordering would drop the new event and raise a false overflow. The bench fills the queue with eight note-ons and then presses key 23 at the start of a scan round. It holds a note read strobe active and releases it at the rising edge that opens cycle 29 of that round (counting cycle 0 as the one in which column 0 first appears), which is key 23's sensing slot. The read therefore ends during that slot, so the pop and the new event's push fall on the same closing clock edge. The result is judged by an overflow bit that stays clear, and by a drain that yields exactly seven old notes followed by note 23.

// File: rtl/vks_pkg.sv
`timescale 1ns/1ps
package vks_pkg;
    localparam int DATA_W = 8;

    typedef enum logic {
        SP_SETTLE = 1'b0,
        SP_SENSE  = 1'b1
    } scan_phase_e;

    typedef enum logic [1:0] {
        KS_IDLE  = 2'd0,
        KS_ARMED = 2'd1,
        KS_HELD  = 2'd2
    } key_state_e;

    typedef enum logic {
        HP_IDLE    = 1'b0,
        HP_NOTE_RD = 1'b1
    } host_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] note;
        logic [DATA_W-1:0] vel;
    } key_event_t;
endpackage

// File: rtl/vks_scan_timer.sv
`timescale 1ns/1ps
module vks_scan_timer import vks_pkg::*; #(
    parameter int NUM_SCAN  = 8,
    parameter int NUM_SENSE = 10,
    parameter int SETTLE    = 2,
    localparam int SUB_W    = $clog2((NUM_SENSE > SETTLE) ? NUM_SENSE : SETTLE),
    localparam int COL_W    = (NUM_SCAN > 1) ? $clog2(NUM_SCAN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [NUM_SCAN-1:0] scan_o,
    output scan_phase_e         phase_o,
    output logic [SUB_W-1:0]    sub_o,
    output logic [COL_W-1:0]    col_o
);
    scan_phase_e      phase, phase_nx;
    logic [SUB_W-1:0] sub, sub_nx;
    logic [COL_W-1:0] col, col_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= SP_SETTLE;
            sub   <= '0;
            col   <= '0;
        end else begin
            phase <= phase_nx;
            sub   <= sub_nx;
            col   <= col_nx;
        end
    end

    // next state
    always_comb begin
        phase_nx = phase;
        col_nx   = col;
        sub_nx   = sub + 1'b1;
        unique case (phase)
            SP_SETTLE: begin
                if (sub == SUB_W'(SETTLE - 1)) begin
                    phase_nx = SP_SENSE;
                    sub_nx   = '0;
                end
            end
            SP_SENSE: begin
                if (sub == SUB_W'(NUM_SENSE - 1)) begin
                    phase_nx = SP_SETTLE;
                    sub_nx   = '0;
                    col_nx   = (col == COL_W'(NUM_SCAN - 1)) ? '0 : col + 1'b1;
                end
            end
            default: begin
                phase_nx = SP_SETTLE;
                sub_nx   = '0;
            end
        endcase
    end

    // outputs
    generate
        for (genvar g = 0; g < NUM_SCAN; g++) begin : g_drive
            assign scan_o[g] = (col == COL_W'(g));
        end
    endgenerate

    assign phase_o = phase;
    assign sub_o   = sub;
    assign col_o   = col;
endmodule

// File: rtl/vks_key_tracker.sv
`timescale 1ns/1ps
module vks_key_tracker import vks_pkg::*; #(
    parameter int NUM_SCAN  = 8,
    parameter int NUM_SENSE = 10,
    parameter int NUM_KEYS  = 61,
    parameter int SUB_W     = 4,
    parameter int COL_W     = 3,
    localparam int TOTAL    = NUM_SCAN * NUM_SENSE,
    localparam int KEY_W    = $clog2(TOTAL),
    localparam int CNT_W    = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot_valid,
    input  logic [COL_W-1:0]     col,
    input  logic [SUB_W-1:0]     sense,
    input  logic [NUM_SENSE-1:0] first_i,
    input  logic [NUM_SENSE-1:0] second_i,
    output logic                 ev_valid,
    output key_event_t           ev_data
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    key_state_e       st_mem  [TOTAL];
    logic [CNT_W-1:0] cnt_mem [TOTAL];

    logic [KEY_W-1:0] key_idx;
    logic             populated, upd;
    logic             f_cl, g_cl;
    key_state_e       cur_st, nx_st;
    logic [CNT_W-1:0] cur_cnt, nx_cnt, vel;
    logic             fire;

    assign key_idx   = KEY_W'(col) * KEY_W'(NUM_SENSE) + KEY_W'(sense);
    assign populated = (key_idx < KEY_W'(NUM_KEYS));
    assign upd       = slot_valid && populated;
    assign f_cl      = first_i[sense];
    assign g_cl      = second_i[sense];
    assign cur_st    = st_mem[key_idx];
    assign cur_cnt   = cnt_mem[key_idx];

    // state register: one slot per cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) begin
                st_mem[i]  <= KS_IDLE;
                cnt_mem[i] <= '0;
            end
        end else if (upd) begin
            st_mem[key_idx]  <= nx_st;
            cnt_mem[key_idx] <= nx_cnt;
        end
    end

    // next state of the key under the scan
    always_comb begin
        nx_st  = cur_st;
        nx_cnt = cur_cnt;
        fire   = 1'b0;
        vel    = '0;
        unique case (cur_st)
            KS_IDLE: begin
                if (f_cl) begin
                    nx_cnt = '0;
                    if (g_cl) begin
                        nx_st = KS_HELD;
                        fire  = 1'b1;
                        vel   = CNT_MAX;
                    end else begin
                        nx_st = KS_ARMED;
                    end
                end
            end
            KS_ARMED: begin
                if (!f_cl) begin
                    nx_st = KS_IDLE;
                end else if (g_cl) begin
                    nx_st = KS_HELD;
                    fire  = 1'b1;
                    vel   = (cur_cnt == CNT_MAX) ? CNT_W'(1) : CNT_MAX - cur_cnt;
                end else if (cur_cnt != CNT_MAX) begin
                    nx_cnt = cur_cnt + 1'b1;
                end
            end
            KS_HELD: begin
                if (!f_cl) begin
                    nx_st = KS_IDLE;
                    fire  = 1'b1;
                    vel   = '0;
                end
            end
            default: nx_st = KS_IDLE;
        endcase
    end

    // event output
    always_comb begin
        ev_valid     = upd && fire;
        ev_data.note = DATA_W'(key_idx);
        ev_data.vel  = vel;
    end
endmodule

// File: rtl/vks_event_fifo.sv
`timescale 1ns/1ps
module vks_event_fifo import vks_pkg::*; #(
    parameter int DEPTH     = 8,
    localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int FCNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  key_event_t        push_data,
    input  logic              pop,
    input  logic              clr_ovf,
    output key_event_t        head,
    output logic [FCNT_W-1:0] count,
    output logic              full,
    output logic              empty,
    output logic              ovf
);
    key_event_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_pop, do_push, drop;

    assign empty   = (count == '0);
    assign full    = (count == FCNT_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign drop    = push && !do_push;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + FCNT_W'(do_push) - FCNT_W'(do_pop);
            // a drop outranks a clear in the same cycle
            if (drop)
                ovf <= 1'b1;
            else if (clr_ovf)
                ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/vks_host_port.sv
`timescale 1ns/1ps
module vks_host_port import vks_pkg::*; #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  key_event_t        head,
    input  logic              empty,
    input  logic              ovf,
    output logic [DATA_W-1:0] rd_data,
    output logic              drive_en,
    output logic              pop,
    output logic              clr_ovf
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_NOTE   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_VEL    = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(3);

    host_state_e st, st_nx;
    logic        note_rd;

    assign note_rd = !cs_n && !rd_n && (addr == A_NOTE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= HP_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            HP_IDLE:    if (note_rd)  st_nx = HP_NOTE_RD;
            HP_NOTE_RD: if (!note_rd) st_nx = HP_IDLE;
            default:    st_nx = HP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pop      = (st == HP_NOTE_RD) && !note_rd;
        clr_ovf  = !cs_n && !wr_n && (addr == A_CLEAR);
        drive_en = !cs_n && !rd_n;
        rd_data  = '0;
        unique case (addr)
            A_STATUS: rd_data = {{(DATA_W-2){1'b0}}, ovf, !empty};
            A_NOTE:   rd_data = empty ? '0 : head.note;
            A_VEL:    rd_data = empty ? '0 : head.vel;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/velo_keyscan.sv
`timescale 1ns/1ps
module velo_keyscan import vks_pkg::*; #(
    parameter int NUM_SCAN   = 8,
    parameter int NUM_SENSE  = 10,
    parameter int SETTLE     = 2,
    parameter int NUM_KEYS   = 61,
    parameter int FIFO_DEPTH = 8,
    parameter int ADDR_W     = 3,
    localparam int SUB_W     = $clog2((NUM_SENSE > SETTLE) ? NUM_SENSE : SETTLE),
    localparam int COL_W     = (NUM_SCAN > 1) ? $clog2(NUM_SCAN) : 1,
    localparam int FCNT_W    = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [NUM_SCAN-1:0]  scan_o,
    input  logic [NUM_SENSE-1:0] first_i,
    input  logic [NUM_SENSE-1:0] second_i,
    input  logic                 cs_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic [ADDR_W-1:0]    addr,
    inout  wire  [DATA_W-1:0]    data_io,
    output logic                 irq_n
);
    scan_phase_e       scan_phase;
    logic [SUB_W-1:0]  scan_sub;
    logic [COL_W-1:0]  scan_col;
    logic              ev_valid;
    key_event_t        ev_data, head;
    logic [FCNT_W-1:0] fifo_cnt;
    logic              fifo_full, fifo_empty, ovf_flag;
    logic              pop, clr_ovf, drive_en;
    logic [DATA_W-1:0] rd_data;

    vks_scan_timer #(
        .NUM_SCAN(NUM_SCAN), .NUM_SENSE(NUM_SENSE), .SETTLE(SETTLE)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .scan_o(scan_o),
        .phase_o(scan_phase), .sub_o(scan_sub), .col_o(scan_col)
    );

    vks_key_tracker #(
        .NUM_SCAN(NUM_SCAN), .NUM_SENSE(NUM_SENSE), .NUM_KEYS(NUM_KEYS),
        .SUB_W(SUB_W), .COL_W(COL_W)
    ) u_keys (
        .clk(clk), .rst_n(rst_n), .slot_valid(scan_phase == SP_SENSE),
        .col(scan_col), .sense(scan_sub),
        .first_i(first_i), .second_i(second_i),
        .ev_valid(ev_valid), .ev_data(ev_data)
    );

    vks_event_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(ev_valid), .push_data(ev_data),
        .pop(pop), .clr_ovf(clr_ovf), .head(head), .count(fifo_cnt),
        .full(fifo_full), .empty(fifo_empty), .ovf(ovf_flag)
    );

    vks_host_port #(.ADDR_W(ADDR_W)) u_host (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .head(head), .empty(fifo_empty), .ovf(ovf_flag),
        .rd_data(rd_data), .drive_en(drive_en), .pop(pop), .clr_ovf(clr_ovf)
    );

    assign data_io = drive_en ? rd_data : 'z;
    assign irq_n   = fifo_empty;
endmodule

// File: rtl/velo_keyscan_chk.sv
`timescale 1ns/1ps
module velo_keyscan_chk import vks_pkg::*; #(
    parameter int NUM_SCAN   = 8,
    parameter int NUM_SENSE  = 10,
    parameter int SETTLE     = 2,
    parameter int NUM_KEYS   = 61,
    parameter int FIFO_DEPTH = 8,
    localparam int SUB_W     = $clog2((NUM_SENSE > SETTLE) ? NUM_SENSE : SETTLE),
    localparam int FCNT_W    = $clog2(FIFO_DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_SCAN-1:0] scan_o,
    input scan_phase_e         scan_phase,
    input logic [SUB_W-1:0]    scan_sub,
    input logic                ev_valid,
    input key_event_t          ev_data,
    input logic [FCNT_W-1:0]   fifo_cnt,
    input logic                fifo_full,
    input logic                ovf_flag
);
    a_r1_one_column: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(scan_o) == 1);

    a_r1_column_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_phase == SP_SETTLE && scan_sub == '0) |-> $stable(scan_o));

    a_r7_populated_only: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (ev_data.note < DATA_W'(NUM_KEYS)));

    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= FCNT_W'(FIFO_DEPTH));

    a_r10_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !$past(ovf_flag)) |-> $past(fifo_full));
endmodule

bind velo_keyscan velo_keyscan_chk #(
    .NUM_SCAN(NUM_SCAN), .NUM_SENSE(NUM_SENSE), .SETTLE(SETTLE),
    .NUM_KEYS(NUM_KEYS), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .scan_o(scan_o), .scan_phase(scan_phase),
    .scan_sub(scan_sub), .ev_valid(ev_valid), .ev_data(ev_data),
    .fifo_cnt(fifo_cnt), .fifo_full(fifo_full), .ovf_flag(ovf_flag)
);

// File: tb/velo_keyscan_test.sv
`timescale 1ns/1ps
module velo_keyscan_test;
    localparam int NS    = 8;
    localparam int SN    = 10;
    localparam int SETL  = 2;
    localparam int DWELL = SETL + SN;
    localparam int NK    = NS * SN;

    // key, delay in scan rounds, expected velocity
    localparam int VEC_N = 6;
    localparam int VEC [VEC_N][3] = '{
        '{5, 0, 255}, '{12, 1, 255}, '{17, 3, 253},
        '{42, 10, 246}, '{60, 2, 254}, '{33, 50, 206}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] scan_o;
    logic [SN-1:0] first_i, second_i;
    logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0]    addr = '0;
    wire  [7:0]    data_bus;
    logic          tb_drv = 1'b0;
    logic [7:0]    tb_wd = '0;
    logic          irq_n;
    logic          key_f [NK];
    logic          key_g [NK];
    logic [NS-1:0] last_scan;
    int            total = 0;
    int            bad = 0;
    int            v;

    assign data_bus = tb_drv ? tb_wd : 8'hzz;

    always #2.5 clk = ~clk;

    velo_keyscan uut (
        .clk(clk), .rst_n(rst_n), .scan_o(scan_o),
        .first_i(first_i), .second_i(second_i),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .data_io(data_bus), .irq_n(irq_n)
    );

    // keyboard model
    always_comb begin
        first_i  = '0;
        second_i = '0;
        for (int c = 0; c < NS; c++)
            if (scan_o[c])
                for (int s = 0; s < SN; s++) begin
                    first_i[s]  = key_f[c*SN + s];
                    second_i[s] = key_g[c*SN + s];
                end
    end

    always @(posedge clk) last_scan <= scan_o;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_keys();
        for (int k = 0; k < NK; k++) begin
            key_f[k] = 1'b0;
            key_g[k] = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clear_keys();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // first cycle of column 0
    task automatic wait_sync();
        do @(negedge clk); while (!(scan_o == NS'(1) && last_scan != NS'(1)));
    endtask

    task automatic host_read(input int a, output int val);
        @(negedge clk);
        addr = 3'(a); cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        val = int'(data_bus);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_write(input int a);
        @(negedge clk);
        addr = 3'(a); tb_wd = 8'hff; tb_drv = 1'b1; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; tb_drv = 1'b0;
        @(negedge clk);
    endtask

    task automatic stroke(input int k, input int gap, input int exp_vel);
        wait_sync();
        key_f[k] = 1'b1;
        if (gap == 0) key_g[k] = 1'b1;
        else begin
            repeat (gap) wait_sync();
            key_g[k] = 1'b1;
        end
        wait_sync();
        host_read(0, v); chk("R9 status with event", v, 1);
        chk("R9 irq low with event", int'(irq_n), 0);
        host_read(2, v); chk($sformatf("R3/R4 velocity key %0d", k), v, exp_vel);
        host_read(1, v); chk("R2 note number", v, k);
        host_read(0, v); chk("R8 popped to empty", v, 0);
        wait_sync();
        key_f[k] = 1'b0; key_g[k] = 1'b0;
        wait_sync();
        host_read(2, v); chk("R6 note-off velocity", v, 0);
        host_read(1, v); chk("R6 note-off note", v, k);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_keys();
        do_reset();
        // reset state
        @(negedge clk);
        chk("R1 column 0 after reset", int'(scan_o), 1);
        chk("R9 irq idle after reset", int'(irq_n), 1);
        host_read(0, v); chk("R9 status after reset", v, 0);
        host_read(1, v); chk("R8 empty note read", v, 0);
        host_read(5, v); chk("R9 unused address", v, 0);

        // column rotation
        wait_sync();
        repeat (DWELL) @(negedge clk);
        chk("R1 column 1", int'(scan_o), 2);
        repeat (DWELL * 6) @(negedge clk);
        chk("R1 column 7", int'(scan_o), 128);
        repeat (DWELL) @(negedge clk);
        chk("R1 wrap to column 0", int'(scan_o), 1);

        // table of strokes
        for (int i = 0; i < VEC_N; i++)
            stroke(VEC[i][0], VEC[i][1], VEC[i][2]);

        // saturation
        stroke(7, 254, 2);
        stroke(8, 300, 1);

        // aborted stroke
        wait_sync(); key_f[20] = 1'b1;
        wait_sync(); key_f[20] = 1'b0;
        wait_sync(); wait_sync();
        host_read(0, v); chk("R5 abort leaves queue empty", v, 0);
        chk("R5 irq stays high", int'(irq_n), 1);

        // unpopulated positions
        wait_sync();
        key_f[61] = 1'b1; key_g[61] = 1'b1; key_f[79] = 1'b1; key_g[79] = 1'b1;
        wait_sync(); wait_sync();
        host_read(0, v); chk("R7 unpopulated no event", v, 0);

        // overflow and clear
        do_reset();
        wait_sync();
        for (int k = 0; k < 9; k++) begin key_f[k] = 1'b1; key_g[k] = 1'b1; end
        wait_sync();
        host_read(0, v); chk("R10 overflow set", v, 3);
        host_write(3);
        host_read(0, v); chk("R10 overflow cleared", v, 1);
        for (int k = 0; k < 8; k++) begin
            host_read(1, v); chk("R8 arrival order", v, k);
        end
        host_read(0, v); chk("R10 drained, ninth dropped", v, 0);

        // pop and push on the same edge with a full queue
        do_reset();
        wait_sync();
        for (int k = 0; k < 8; k++) begin key_f[k] = 1'b1; key_g[k] = 1'b1; end
        wait_sync();
        key_f[23] = 1'b1; key_g[23] = 1'b1;
        addr = 3'd1; cs_n = 1'b0; rd_n = 1'b0;
        repeat (2*DWELL + SETL + 3 - 1) @(negedge clk);
        chk("R11 head during held read", int'(data_bus), 0);
        @(posedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk); @(negedge clk);
        host_read(0, v); chk("R11 no overflow on simultaneous edge", v, 1);
        for (int k = 1; k < 8; k++) begin
            host_read(1, v); chk("R11 older entries kept", v, k);
        end
        host_read(1, v); chk("R11 new event accepted last", v, 23);
        host_read(0, v); chk("R11 exactly eight entries", v, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule